// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Option

This block carries 18-bit words from a write clock domain to a read clock domain. The two clocks may be the same net or fully unrelated. The write side stores one word per write-clock edge while space remains. The read side hands words out of a registered output stage in one of two timing modes, which is captured at reset. In standard mode the consumer pulls each word with a read strobe. In fall-through mode the oldest word moves to the output by itself, and the read strobe only retires it.

Pointers cross between the domains as Gray codes through two-flop synchronizers. Each side derives its own status flags from its local pointer and the synchronized copy of the other pointer. Two programmable thresholds set an almost-empty flag and an almost-full flag. Software loads both thresholds through the write port while a load strobe is held. A half-full flag reports occupancy above the midpoint. An output-enable input gates the read-side valid indication and never drives a tri-state pad.

Top module: `dcf_fifo_top`

## Requirements
- R1: After reset in standard mode: rd_status=1, wr_status=0, almost_empty=1, almost_full=0, half_full=0, rd_valid=0 and rd_data=0. After reset in fall-through mode: rd_status=0 and wr_status=1.
- R2: Every accepted word leaves the read port exactly once, in write order. In standard mode wr_status (full) rises once DEPTH words are stored.
- R3: In standard mode a stored word does not reach rd_data until a read is made. rd_en high at a read-clock edge while words are available loads rd_data and raises rd_valid for that one cycle. rd_data otherwise holds.
- R4: In fall-through mode, with the clocks tied, a word written at edge k into an empty FIFO is on rd_data with rd_status (output-ready) high after edge k+3, and no rd_en is needed. rd_en high while ready retires the word.
- R5: In fall-through mode wr_status means input-ready (1 while space remains). With no reads, DEPTH+1 words are accepted before it drops: DEPTH in storage plus one in the output stage.
- R6: While load=1, each wr_en cycle writes wr_data[AW:0] into a threshold register and stores nothing in the FIFO. The first cycle writes the almost-empty offset, the second the almost-full offset, and the order then wraps. Dropping load returns the order to the almost-empty offset. Both offsets are 7 after reset.
- R7: almost_empty is 1 when the stored word count, as seen by the read side, is at most the almost-empty offset. almost_full is 1 when the stored count, as seen by the write side, is at least DEPTH minus the almost-full offset.
- R8: half_full is 1 when the stored word count exceeds DEPTH/2.
- R9: A write while full, or a read while empty, changes no pointer and no stored word.
- R10: With out_en=0, rd_valid stays 0 while reads still advance rd_data.
- R11: In standard mode, with tied clocks, rd_status (empty) falls two read-clock edges after the write edge that fills an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain synchronously |
| mode_fwft | input | 1 | Mode select sampled at reset: 0 standard, 1 fall-through |
| wr_en | input | 1 | Write strobe (threshold load when load=1) |
| wr_data | input | 18 | Write data |
| load | input | 1 | Routes wr_en cycles to the threshold registers |
| rd_en | input | 1 | Read strobe |
| out_en | input | 1 | Gates rd_valid |
| rd_data | output | 18 | Registered output word |
| rd_valid | output | 1 | Output word valid, gated by out_en |
| rd_status | output | 1 | Empty (standard) or output-ready (fall-through) |
| wr_status | output | 1 | Full (standard) or input-ready (fall-through) |
| almost_empty | output | 1 | Occupancy at or under the almost-empty offset |
| almost_full | output | 1 | Occupancy at or over DEPTH minus the almost-full offset |
| half_full | output | 1 | Occupancy above DEPTH/2 |

## Verification
The bench checks the exact edge at which a first word becomes visible in each mode. A design that let a word fall through in standard mode, or that miscounted synchronizer stages, would fail these checks at the wrong sample cycle. It fills to capacity in both modes and pushes once more, so an off-by-one full compare or a fall-through stage left out of the capacity shows up as an extra word or a missing one. The threshold sequencer is driven past its wrap point, so a swapped or non-wrapping order leaves the almost flags switching at the wrong occupancy. Reads on an empty FIFO and writes on a full one are followed by normal traffic, so a pointer that moved anyway shows up as a stale or skipped word.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} dcf_mode_e;
  typedef enum logic {SEL_AE = 1'b0, SEL_AF = 1'b1} dcf_ldsel_e;
endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
  import dcf_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int DATA_W  = 18,
  parameter int OFF_RST = 7,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_in,
  input  logic              wr_en,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PW-1:0]     rgray_sync,
  output logic [PW-1:0]     wgray,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic              wr_status,
  output logic              almost_full,
  output logic              half_full,
  output logic [PW-1:0]     ae_off
);
  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0] rbin_sync, wcount;
  logic [PW-1:0] ae_q, ae_d, af_q, af_d;
  logic [PW:0]   af_thr;
  dcf_ldsel_e    sel_q, sel_d;
  logic          armed_q;
  dcf_mode_e     mode_q;
  logic          full, push;

  // mode capture: follows the input while in reset and on the first cycle out
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!armed_q) mode_q <= dcf_mode_e'(mode_in);
  end

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_sync[i] = ^(rgray_sync >> i);
  end

  assign wcount = wbin_q - rbin_sync;
  assign full   = (wgray_q == {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]});
  assign push   = wr_en & ~load & ~full;

  always_comb begin
    wbin_d  = wbin_q + PW'(push);
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  // threshold load sequencer
  always_comb begin
    ae_d  = ae_q;
    af_d  = af_q;
    sel_d = sel_q;
    if (load) begin
      if (wr_en) begin
        if (sel_q == SEL_AE) ae_d = wdata[PW-1:0];
        else                 af_d = wdata[PW-1:0];
        sel_d = (sel_q == SEL_AE) ? SEL_AF : SEL_AE;
      end
    end else begin
      sel_d = SEL_AE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ae_q    <= PW'(OFF_RST);
      af_q    <= PW'(OFF_RST);
      sel_q   <= SEL_AE;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      ae_q    <= ae_d;
      af_q    <= af_d;
      sel_q   <= sel_d;
    end
  end

  assign af_thr      = (PW+1)'(DEPTH) - (PW+1)'(af_q);
  assign almost_full = ({1'b0, wcount} >= af_thr);
  assign half_full   = (wcount > PW'(DEPTH / 2));
  assign wr_status   = (mode_q == MODE_FWFT) ? ~full : full;
  assign wgray       = wgray_q;
  assign mem_we      = push;
  assign mem_waddr   = wbin_q[AW-1:0];
  assign ae_off      = ae_q;

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> $stable(wbin_q));
  assert_full_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (wcount == PW'(DEPTH)));
  assert_wcount_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wcount <= PW'(DEPTH));
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
  import dcf_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 18,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_in,
  input  logic              rd_en,
  input  logic              out_en,
  input  logic [PW-1:0]     wgray_sync,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [PW-1:0]     ae_off,
  output logic [PW-1:0]     rgray,
  output logic [AW-1:0]     mem_raddr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_status,
  output logic              almost_empty
);
  logic [PW-1:0]     rbin_q, rbin_d, rgray_q, rgray_d;
  logic [PW-1:0]     wbin_sync, rcount;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic              vld_q, vld_d;
  logic              armed_q;
  dcf_mode_e         mode_q;
  logic              empty, pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!armed_q) mode_q <= dcf_mode_e'(mode_in);
  end

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_sync[i] = ^(wgray_sync >> i);
  end

  assign rcount = wbin_sync - rbin_q;
  assign empty  = (rgray_q == wgray_sync);

  always_comb begin
    if (mode_q == MODE_FWFT) begin
      pop   = ~empty & (~vld_q | rd_en);
      vld_d = pop ? 1'b1 : (rd_en ? 1'b0 : vld_q);
    end else begin
      pop   = rd_en & ~empty;
      vld_d = pop;
    end
    dout_d  = pop ? mem_rdata : dout_q;
    rbin_d  = rbin_q + PW'(pop);
    rgray_d = rbin_d ^ (rbin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      dout_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      dout_q  <= dout_d;
      vld_q   <= vld_d;
    end
  end

  assign rgray        = rgray_q;
  assign mem_raddr    = rbin_q[AW-1:0];
  assign rd_data      = dout_q;
  assign rd_valid     = out_en & vld_q;
  assign rd_status    = (mode_q == MODE_FWFT) ? vld_q : empty;
  assign almost_empty = (rcount <= ae_off);

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> $stable(rbin_q));
  assert_std_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STD && !rd_en) |=> $stable(dout_q));
  assert_fwft_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FWFT && vld_q && !rd_en) |=> (vld_q && $stable(dout_q)));
  assert_rcount_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rcount <= PW'(DEPTH));
endmodule

// File: rtl/dcf_fifo_top.sv
module dcf_fifo_top #(
  parameter int DEPTH   = 256,
  parameter int DATA_W  = 18,
  parameter int OFF_RST = 7
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              mode_fwft,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  input  logic              rd_en,
  input  logic              out_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_status,
  output logic              wr_status,
  output logic              almost_empty,
  output logic              almost_full,
  output logic              half_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic              wrst_n, rrst_n;
  logic [PW-1:0]     wgray, rgray, wgray_rs, rgray_ws, ae_off;
  logic              mem_we;
  logic [AW-1:0]     mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] mem [DEPTH];

  dcf_rst_sync #(.STAGES(2)) u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wrst_n));
  dcf_rst_sync #(.STAGES(2)) u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rrst_n));

  dcf_gray_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_rs));
  dcf_gray_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_ws));

  dcf_wr_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .OFF_RST(OFF_RST)) u_wr (
    .clk(wr_clk), .rst_n(wrst_n), .mode_in(mode_fwft), .wr_en(wr_en), .load(load),
    .wdata(wr_data), .rgray_sync(rgray_ws), .wgray(wgray), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .wr_status(wr_status), .almost_full(almost_full),
    .half_full(half_full), .ae_off(ae_off)
  );

  dcf_rd_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rd (
    .clk(rd_clk), .rst_n(rrst_n), .mode_in(mode_fwft), .rd_en(rd_en), .out_en(out_en),
    .wgray_sync(wgray_rs), .mem_rdata(mem_rdata), .ae_off(ae_off), .rgray(rgray),
    .mem_raddr(mem_raddr), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_status(rd_status), .almost_empty(almost_empty)
  );

  // storage: written in the write domain, read combinationally in the read domain
  always_ff @(posedge wr_clk) begin
    if (mem_we) mem[mem_waddr] <= wr_data;
  end

  assign mem_rdata = mem[mem_raddr];
endmodule

// File: tb/tb_dcf_fifo_top.sv
`timescale 1ns/1ps
module tb_dcf_fifo_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n, mode_fwft, wr_en, load, rd_en, out_en;
  logic [17:0] wr_data;
  logic [17:0] rd_data;
  logic        rd_valid, rd_status, wr_status, almost_empty, almost_full, half_full;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [17:0] q[$];
  logic [17:0] seq = 18'h100;

  always #4 clk = ~clk;

  dcf_fifo_top #(.DEPTH(DEPTH)) dut (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .mode_fwft(mode_fwft),
    .wr_en(wr_en), .wr_data(wr_data), .load(load), .rd_en(rd_en), .out_en(out_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_status(rd_status),
    .wr_status(wr_status), .almost_empty(almost_empty), .almost_full(almost_full),
    .half_full(half_full)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit std_full();
    return (mode_fwft == 1'b0) ? wr_status : ~wr_status;
  endfunction

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic m);
    rst_n = 1'b0; mode_fwft = m; wr_en = 0; load = 0; rd_en = 0; out_en = 1; wr_data = '0;
    q.delete();
    settle(3);
    rst_n = 1'b1;
    settle(4);
  endtask

  // one write cycle; the model records it when space was reported before the edge
  task automatic push(input logic [17:0] d);
    if (!std_full()) q.push_back(d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) begin
      push(seq);
      seq = seq + 18'd1;
    end
  endtask

  // standard-mode read cycle with order check
  task automatic read_std(input string req);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    if (rd_valid) begin
      chk(req, rd_data, (q.size() > 0) ? int'(q[0]) : -1);
      if (q.size() > 0) void'(q.pop_front());
    end
  endtask

  task automatic drain_std(input string req);
    for (int i = 0; i < DEPTH + 8; i++) read_std(req);
    chk({req, " drained"}, q.size(), 0);
  endtask

  task automatic drain_fwft(input string req);
    for (int i = 0; i < 4 * DEPTH + 16; i++) begin
      if (rd_status) begin
        chk(req, rd_data, (q.size() > 0) ? int'(q[0]) : -1);
        if (q.size() > 0) void'(q.pop_front());
        rd_en = 1'b1;
      end else rd_en = 1'b0;
      @(negedge clk);
    end
    rd_en = 1'b0;
    chk({req, " drained"}, q.size(), 0);
  endtask

  task automatic load_offsets(input logic [17:0] a, input logic [17:0] b, input logic [17:0] c, input int n);
    load = 1'b1;
    wr_en = 1'b1; wr_data = a; @(negedge clk);
    wr_data = b; @(negedge clk);
    if (n > 2) begin wr_data = c; @(negedge clk); end
    wr_en = 1'b0; load = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // ---------------- standard mode ----------------
    do_reset(1'b0);
    @(negedge clk);
    chk("R1 empty", rd_status, 1);
    chk("R1 full", wr_status, 0);
    chk("R1 ae", almost_empty, 1);
    chk("R1 af", almost_full, 0);
    chk("R1 hf", half_full, 0);
    chk("R1 valid", rd_valid, 0);
    chk("R1 data", rd_data, 0);

    // R11 / R3: sync latency and no fall-through
    push(18'h2A5A5);
    chk("R11 empty after k", rd_status, 1);
    @(negedge clk);
    chk("R11 empty after k+1", rd_status, 1);
    @(negedge clk);
    chk("R11 empty after k+2", rd_status, 0);
    settle(3);
    chk("R3 no fall-through data", rd_data, 0);
    chk("R3 no fall-through valid", rd_valid, 0);
    read_std("R3 read data");
    chk("R3 valid pulse", rd_valid, 1);
    @(negedge clk);
    chk("R3 valid one cycle", rd_valid, 0);
    chk("R3 data holds", rd_data, 18'h2A5A5);

    // R9: read while empty ignored
    settle(2);
    read_std("R9 empty read");
    chk("R9 no valid on empty read", rd_valid, 0);
    push(18'h0BEEF);
    settle(4);
    read_std("R9 word after empty read");
    chk("R9 model empty", q.size(), 0);

    // R7 / R8 with default offsets 7
    push_n(7); settle(4);
    chk("R7 ae at 7", almost_empty, 1);
    push_n(1); settle(4);
    chk("R7 ae at 8", almost_empty, 0);
    chk("R8 hf at 8", half_full, 0);
    chk("R7 af at 8", almost_full, 0);
    push_n(1); settle(1);
    chk("R8 hf at 9", half_full, 1);
    chk("R7 af at 9", almost_full, 1);
    settle(4);
    drain_std("R2 order");
    settle(4);

    // R6: load af=4, ae=3; nothing stored
    load_offsets(18'd3, 18'd4, 18'd0, 2);
    settle(4);
    chk("R6 load stores nothing", rd_status, 1);
    push_n(3); settle(4);
    chk("R6 ae at 3 with off 3", almost_empty, 1);
    push_n(1); settle(4);
    chk("R6 ae at 4 with off 3", almost_empty, 0);
    push_n(7); settle(1);
    chk("R6 af at 11 with off 4", almost_full, 0);
    push_n(1); settle(1);
    chk("R6 af at 12 with off 4", almost_full, 1);
    push_n(4); settle(1);
    chk("R2 full at DEPTH", wr_status, 1);
    push(18'h3FFFF);
    chk("R9 overflow not recorded", q.size(), DEPTH);
    settle(4);
    drain_std("R9 order after overflow");
    push(18'h01234); settle(4);
    read_std("R9 next word after overflow");
    chk("R9 no stray word", rd_valid, 1);
    settle(4);

    // R6 wrap: three load writes -> ae=2, af=12
    load_offsets(18'd5, 18'd12, 18'd2, 3);
    push_n(2); settle(4);
    chk("R6 wrap ae at 2", almost_empty, 1);
    push_n(1); settle(4);
    chk("R6 wrap ae at 3", almost_empty, 0);
    chk("R6 af off 12 at 3", almost_full, 0);
    push_n(1); settle(1);
    chk("R6 af off 12 at 4", almost_full, 1);
    settle(4);
    drain_std("R6 drain");

    // R10: out_en gates valid only
    out_en = 1'b0;
    push(18'h15555); settle(4);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    chk("R10 valid gated", rd_valid, 0);
    chk("R10 data moved", rd_data, 18'h15555);
    void'(q.pop_front());
    out_en = 1'b1;
    settle(2);

    // random traffic, standard mode
    for (int i = 0; i < 800; i++) begin
      if (rd_valid) begin
        chk("R2 random order", rd_data, (q.size() > 0) ? int'(q[0]) : -1);
        if (q.size() > 0) void'(q.pop_front());
      end
      if (($urandom % 100) < 50) begin
        if (!std_full()) q.push_back(seq);
        wr_en = 1'b1; wr_data = seq; seq = seq + 18'd1;
      end else wr_en = 1'b0;
      rd_en = (($urandom % 100) < 45);
      @(negedge clk);
    end
    wr_en = 1'b0; rd_en = 1'b0;
    if (rd_valid) begin
      chk("R2 random order", rd_data, (q.size() > 0) ? int'(q[0]) : -1);
      if (q.size() > 0) void'(q.pop_front());
    end
    settle(4);
    drain_std("R2 random drain");

    // ---------------- fall-through mode ----------------
    do_reset(1'b1);
    @(negedge clk);
    chk("R1 fwft not ready", rd_status, 0);
    chk("R1 fwft input ready", wr_status, 1);
    push(18'h00ABC);
    chk("R4 ready after k", rd_status, 0);
    @(negedge clk);
    chk("R4 ready after k+1", rd_status, 0);
    @(negedge clk);
    chk("R4 ready after k+2", rd_status, 0);
    @(negedge clk);
    chk("R4 ready after k+3", rd_status, 1);
    chk("R4 data fell through", rd_data, 18'h00ABC);
    chk("R4 valid", rd_valid, 1);
    settle(3);
    chk("R4 held without rd_en", rd_status, 1);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    void'(q.pop_front());
    chk("R4 retired", rd_status, 0);
    settle(4);

    // R5: DEPTH+1 accepted
    push_n(DEPTH + 2);
    chk("R5 accepted count", q.size(), DEPTH + 1);
    chk("R5 input not ready", wr_status, 0);
    drain_fwft("R5 order");
    settle(4);
    chk("R5 input ready again", wr_status, 1);

    // random traffic, fall-through mode
    for (int i = 0; i < 800; i++) begin
      if (rd_status && (($urandom % 100) < 45)) begin
        chk("R4 random order", rd_data, (q.size() > 0) ? int'(q[0]) : -1);
        if (q.size() > 0) void'(q.pop_front());
        rd_en = 1'b1;
      end else rd_en = 1'b0;
      if (($urandom % 100) < 50) begin
        if (!std_full()) q.push_back(seq);
        wr_en = 1'b1; wr_data = seq; seq = seq + 18'd1;
      end else wr_en = 1'b0;
      @(negedge clk);
    end
    wr_en = 1'b0; rd_en = 1'b0;
    drain_fwft("R4 random drain");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule